// File: doc/BRIEF.md
# Dual-Flash Quad-SPI Lane Router

This block sits between one quad-SPI shift engine and one or two quad-SPI flash devices. A configuration input picks one of three wirings: a single device on one chip select and one 4-line group, two devices in parallel that share a chip select and each own a 4-line group (8 lines in all), or two stacked devices that share one 4-line group and each have their own chip select. The router steers chip selects, outgoing nibbles, output enables and returning nibbles to suit the wiring, and turns the flat byte address the host sees into a per-device 3-byte address plus a bank number.

A transaction opens with a one-cycle `txn_start` that captures the mode, the stacked select bit, the host address and the length. It closes with a one-cycle `txn_end`. Between the two, the engine states the phase (command, address, write data or read data) and supplies a byte. In parallel mode, command and address nibbles go out on both groups alike. Each data byte is split so that its low nibble goes to the first device and its high nibble to the second, and read nibbles are joined back the same way. In stacked mode, a host address in the upper half picks the second device and has one device size taken off. A transaction that carries no address picks its stacked device from a select bit.

Top module: `qspi_lane_router`

## Requirements
- R1: After synchronous reset, both chip selects are high (deasserted), `addr_err` is 0 and both output enables are 0.
- R2: Single mode (`cfg_mode`=0) asserts `cs0_n` only. Group 0 carries `tx_byte[3:0]`, group 1 is never enabled, `rx_byte` is {4'h0, `g0_io_i`} during read data, and the device address equals the host address.
- R3: Parallel mode (`cfg_mode`=1) drives `tx_byte[3:0]` identically on both groups during command (`phase`=1) and address (`phase`=2).
- R4: In parallel mode, during write data (`phase`=3), group 0 carries `tx_byte[3:0]` and group 1 carries `tx_byte[7:4]`.
- R5: In parallel mode, during read data (`phase`=4), `rx_byte` is {`g1_io_i`, `g0_io_i`}.
- R6: In parallel mode, both chip selects assert together and the device address is the host address shifted right by one.
- R7: In parallel mode, an address-carrying transaction with an odd host address or an odd length sets `addr_err` and asserts no chip select.
- R8: Stacked mode (`cfg_mode`=2) uses only group 0 and never asserts both chip selects. A host address at or above DEV_BYTES asserts `cs1_n` and subtracts DEV_BYTES; a lower address asserts `cs0_n` and passes unchanged.
- R9: In stacked mode, a transaction with `txn_use_addr`=0 selects device 1 when `cfg_stack_sel`=1 and device 0 otherwise.
- R10: A host address at or above DEV_BYTES in single mode, or at or above 2*DEV_BYTES in the dual modes, and any transaction with `cfg_mode`=3, sets `addr_err`. In that case no chip select and no output enable is asserted.
- R11: Output enables are asserted only during command, address and write-data phases of an open, error-free transaction. They are never asserted during read data or while idle.
- R12: The device-local address is given as its low 24 bits on `dev_addr` and its remaining upper bits on `dev_bank`.
- R13: The settings captured at `txn_start` hold until `txn_end`. Changing `cfg_mode` or the address inputs mid-transaction does not alter the chip selects or the lane routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 single, 1 parallel, 2 stacked, 3 reserved |
| cfg_stack_sel | input | 1 | Stacked device select for transactions without an address |
| txn_start | input | 1 | Opens a transaction and captures the settings |
| txn_end | input | 1 | Closes the open transaction |
| txn_use_addr | input | 1 | Transaction carries a host address |
| host_addr | input | HOST_AW | Flat host byte address |
| host_len | input | LEN_W | Transfer length in bytes |
| phase | input | 3 | 0 idle, 1 command, 2 address, 3 write data, 4 read data |
| tx_byte | input | 8 | Outgoing nibble (bits 3:0) or data byte from the engine |
| rx_byte | output | 8 | Returned data to the engine |
| g0_io_i | input | 4 | Group 0 lanes in |
| g0_io_o | output | 4 | Group 0 lanes out |
| g0_io_oe | output | 1 | Group 0 output enable |
| g1_io_i | input | 4 | Group 1 lanes in |
| g1_io_o | output | 4 | Group 1 lanes out |
| g1_io_oe | output | 1 | Group 1 output enable |
| cs0_n | output | 1 | Device 0 chip select, active low |
| cs1_n | output | 1 | Device 1 chip select, active low |
| dev_addr | output | 24 | Device-local 3-byte address |
| dev_bank | output | BANK_W | Device-local bank number |
| addr_err | output | 1 | Captured transaction is invalid |

## Verification
The hardest situation to reach is a configuration change in the middle of an open transaction. The routing must follow the captured mode and not the live input, and that difference shows only when the two disagree during a data phase. The bench opens a parallel transaction, switches `cfg_mode` to single and scrambles the address inputs. It then drives a write-data byte and checks that the nibble split and both chip selects persist. Boundary addresses exactly at DEV_BYTES and at 2*DEV_BYTES, and parallel requests with odd address or length, come from a vector table.

// File: rtl/qlr_pkg.sv
package qlr_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_PARALLEL = 2'd1,
        MODE_STACKED  = 2'd2,
        MODE_RSVD     = 2'd3
    } lane_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_WDATA = 3'd3,
        PH_RDATA = 3'd4
    } xfer_phase_e;

    localparam int NUM_GROUPS = 2;
    localparam int GROUP_W    = 4;
    localparam int ADDR3_W    = 24;

    // Phases in which the router owns the lanes.
    function automatic logic phase_drives(xfer_phase_e p);
        return (p == PH_CMD) || (p == PH_ADDR) || (p == PH_WDATA);
    endfunction

    // Whether lane group g is wired to a device in mode m.
    function automatic logic group_used(lane_mode_e m, int g);
        if (g == 0) return (m != MODE_RSVD);
        return (m == MODE_PARALLEL);
    endfunction

endpackage

// File: rtl/qlr_addr_map.sv
module qlr_addr_map
    import qlr_pkg::*;
#(
    parameter int          HOST_AW   = 32,
    parameter int          LEN_W     = 16,
    parameter int unsigned DEV_BYTES = 32'h0200_0000,
    parameter int          DEV_AW    = 25
) (
    input  lane_mode_e          mode,
    input  logic                stack_sel,
    input  logic                use_addr,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [LEN_W-1:0]    host_len,
    output logic [DEV_AW-1:0]   dev_local,
    output logic                sel_hi,
    output logic                err
);
    localparam logic [HOST_AW:0] ONE_DEV = (HOST_AW+1)'(DEV_BYTES);
    localparam logic [HOST_AW:0] TWO_DEV = ONE_DEV << 1;

    logic [HOST_AW:0] addr_x;
    logic [HOST_AW:0] local_x;
    logic             in_range;
    logic             upper;
    logic             odd;

    always_comb begin
        addr_x   = {1'b0, host_addr};
        in_range = (mode == MODE_SINGLE) ? (addr_x < ONE_DEV) : (addr_x < TWO_DEV);
        upper    = (addr_x >= ONE_DEV);
        local_x  = '0;
        sel_hi   = 1'b0;
        odd      = 1'b0;
        unique case (mode)
            MODE_SINGLE:   local_x = addr_x;
            MODE_PARALLEL: begin
                local_x = addr_x >> 1;
                odd     = host_addr[0] | host_len[0];
            end
            MODE_STACKED: begin
                local_x = upper ? (addr_x - ONE_DEV) : addr_x;
                sel_hi  = use_addr ? upper : stack_sel;
            end
            default: ;
        endcase
        if (!use_addr) local_x = '0;
        err       = (mode == MODE_RSVD) || (use_addr && (!in_range || odd));
        dev_local = local_x[DEV_AW-1:0];
    end

endmodule

// File: rtl/qlr_cs_ctrl.sv
module qlr_cs_ctrl
    import qlr_pkg::*;
#(
    parameter int DEV_AW = 25,
    parameter int BANK_W = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_start,
    input  logic               txn_end,
    input  lane_mode_e         mode_in,
    input  logic               sel_hi_in,
    input  logic               err_in,
    input  logic [DEV_AW-1:0]  local_in,
    output lane_mode_e         mode_q,
    output logic               live,
    output logic               err_q,
    output logic               cs0_n,
    output logic               cs1_n,
    output logic [ADDR3_W-1:0] dev_addr,
    output logic [BANK_W-1:0]  dev_bank
);
    localparam int PAD_W = ADDR3_W + BANK_W;

    logic              active_q;
    logic              sel_q;
    logic [PAD_W-1:0]  addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sel_q    <= 1'b0;
            err_q    <= 1'b0;
            mode_q   <= MODE_SINGLE;
            addr_q   <= '0;
        end else if (txn_start) begin
            active_q <= 1'b1;
            sel_q    <= sel_hi_in;
            err_q    <= err_in;
            mode_q   <= mode_in;
            addr_q   <= PAD_W'(local_in);
        end else if (txn_end) begin
            active_q <= 1'b0;
        end
    end

    always_comb begin
        live     = active_q && !err_q;
        cs0_n    = !(live && (mode_q == MODE_SINGLE || mode_q == MODE_PARALLEL ||
                              (mode_q == MODE_STACKED && !sel_q)));
        cs1_n    = !(live && (mode_q == MODE_PARALLEL ||
                              (mode_q == MODE_STACKED && sel_q)));
        dev_addr = addr_q[ADDR3_W-1:0];
        dev_bank = addr_q[PAD_W-1:ADDR3_W];
    end

    // R13: an asserted select persists until the transaction is closed
    p_cs_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (!cs0_n && !txn_end && !txn_start) |=> !cs0_n);

endmodule

// File: rtl/qlr_lane_mux.sv
module qlr_lane_mux
    import qlr_pkg::*;
(
    input  logic                            live,
    input  lane_mode_e                      mode_q,
    input  xfer_phase_e                     phase,
    input  logic [7:0]                      tx_byte,
    input  logic [NUM_GROUPS*GROUP_W-1:0]   io_i,
    output logic [NUM_GROUPS*GROUP_W-1:0]   io_o,
    output logic [NUM_GROUPS-1:0]           io_oe,
    output logic [7:0]                      rx_byte
);
    logic split;
    assign split = (mode_q == MODE_PARALLEL);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        always_comb begin
            io_oe[g] = live && phase_drives(phase) && group_used(mode_q, g);
            if (split && phase == PH_WDATA)
                io_o[g*GROUP_W +: GROUP_W] = tx_byte[g*GROUP_W +: GROUP_W];
            else
                io_o[g*GROUP_W +: GROUP_W] = tx_byte[GROUP_W-1:0];
        end
    end

    always_comb begin
        rx_byte = '0;
        if (live && phase == PH_RDATA)
            rx_byte = split ? io_i[7:0] : {4'h0, io_i[GROUP_W-1:0]};
    end

endmodule

// File: rtl/qspi_lane_router.sv
module qspi_lane_router
    import qlr_pkg::*;
#(
    parameter int          HOST_AW   = 32,
    parameter int          LEN_W     = 16,
    parameter int unsigned DEV_BYTES = 32'h0200_0000,
    localparam int         DEV_AW    = $clog2(DEV_BYTES),
    localparam int         BANK_W    = (DEV_AW > ADDR3_W) ? DEV_AW - ADDR3_W : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_stack_sel,
    input  logic               txn_start,
    input  logic               txn_end,
    input  logic               txn_use_addr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [LEN_W-1:0]   host_len,
    input  logic [2:0]         phase,
    input  logic [7:0]         tx_byte,
    output logic [7:0]         rx_byte,
    input  logic [3:0]         g0_io_i,
    output logic [3:0]         g0_io_o,
    output logic               g0_io_oe,
    input  logic [3:0]         g1_io_i,
    output logic [3:0]         g1_io_o,
    output logic               g1_io_oe,
    output logic               cs0_n,
    output logic               cs1_n,
    output logic [23:0]        dev_addr,
    output logic [BANK_W-1:0]  dev_bank,
    output logic               addr_err
);
    lane_mode_e                   mode_q;
    logic                         live;
    logic [DEV_AW-1:0]            map_local;
    logic                         map_sel;
    logic                         map_err;
    logic [NUM_GROUPS*GROUP_W-1:0] io_o_w;
    logic [NUM_GROUPS-1:0]        io_oe_w;

    qlr_addr_map #(
        .HOST_AW(HOST_AW), .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES), .DEV_AW(DEV_AW)
    ) u_map (
        .mode(lane_mode_e'(cfg_mode)), .stack_sel(cfg_stack_sel), .use_addr(txn_use_addr),
        .host_addr(host_addr), .host_len(host_len),
        .dev_local(map_local), .sel_hi(map_sel), .err(map_err)
    );

    qlr_cs_ctrl #(.DEV_AW(DEV_AW), .BANK_W(BANK_W)) u_cs (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_end(txn_end),
        .mode_in(lane_mode_e'(cfg_mode)), .sel_hi_in(map_sel), .err_in(map_err),
        .local_in(map_local), .mode_q(mode_q), .live(live), .err_q(addr_err),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .dev_addr(dev_addr), .dev_bank(dev_bank)
    );

    qlr_lane_mux u_mux (
        .live(live), .mode_q(mode_q), .phase(xfer_phase_e'(phase)), .tx_byte(tx_byte),
        .io_i({g1_io_i, g0_io_i}), .io_o(io_o_w), .io_oe(io_oe_w), .rx_byte(rx_byte)
    );

    assign g0_io_o  = io_o_w[3:0];
    assign g1_io_o  = io_o_w[7:4];
    assign g0_io_oe = io_oe_w[0];
    assign g1_io_oe = io_oe_w[1];

    // R8: stacked devices are never selected together
    p_stack_one_cs_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STACKED) |-> (cs0_n || cs1_n));

    // R6: parallel devices share one select
    p_par_cs_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PARALLEL) |-> (cs0_n == cs1_n));

    // R10: a rejected transaction leaves pins quiet
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (cs0_n && cs1_n && !g0_io_oe && !g1_io_oe));

    // R11: lanes are released while the flash drives them
    p_rdata_hiz_r11: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4) |-> (!g0_io_oe && !g1_io_oe));

endmodule

// File: tb/qspi_lane_router_bench.sv
module qspi_lane_router_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  mode;
        logic        sel;
        logic        use_a;
        logic [31:0] addr;
        logic [15:0] len;
        logic        c0;
        logic        c1;
        logic        err;
        logic [24:0] loc;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b1, 32'h0012_3456, 16'd4, 1'b0, 1'b1, 1'b0, 25'h012_3456},
        '{2'd0, 1'b0, 1'b1, 32'h01FF_FFFF, 16'd1, 1'b0, 1'b1, 1'b0, 25'h1FF_FFFF},
        '{2'd0, 1'b0, 1'b1, 32'h0200_0000, 16'd4, 1'b1, 1'b1, 1'b1, 25'h000_0000},
        '{2'd1, 1'b0, 1'b1, 32'h0246_8ACE, 16'd2, 1'b0, 1'b0, 1'b0, 25'h123_4567},
        '{2'd1, 1'b0, 1'b1, 32'h03FF_FFFE, 16'd2, 1'b0, 1'b0, 1'b0, 25'h1FF_FFFF},
        '{2'd1, 1'b0, 1'b1, 32'h0000_0101, 16'd2, 1'b1, 1'b1, 1'b1, 25'h000_0000},
        '{2'd1, 1'b0, 1'b1, 32'h0000_0100, 16'd3, 1'b1, 1'b1, 1'b1, 25'h000_0000},
        '{2'd1, 1'b0, 1'b1, 32'h0400_0000, 16'd2, 1'b1, 1'b1, 1'b1, 25'h000_0000},
        '{2'd2, 1'b1, 1'b1, 32'h01FF_FFFF, 16'd1, 1'b0, 1'b1, 1'b0, 25'h1FF_FFFF},
        '{2'd2, 1'b0, 1'b1, 32'h0200_0000, 16'd1, 1'b1, 1'b0, 1'b0, 25'h000_0000},
        '{2'd2, 1'b0, 1'b1, 32'h0300_0010, 16'd1, 1'b1, 1'b0, 1'b0, 25'h100_0010},
        '{2'd2, 1'b0, 1'b1, 32'h0400_0000, 16'd1, 1'b1, 1'b1, 1'b1, 25'h000_0000},
        '{2'd2, 1'b1, 1'b0, 32'h0355_0000, 16'd1, 1'b1, 1'b0, 1'b0, 25'h000_0000},
        '{2'd2, 1'b0, 1'b0, 32'h0355_0000, 16'd1, 1'b0, 1'b1, 1'b0, 25'h000_0000},
        '{2'd3, 1'b0, 1'b1, 32'h0000_0010, 16'd2, 1'b1, 1'b1, 1'b1, 25'h000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_stack_sel = 1'b0;
    logic        txn_start = 1'b0;
    logic        txn_end = 1'b0;
    logic        txn_use_addr = 1'b0;
    logic [31:0] host_addr = '0;
    logic [15:0] host_len = '0;
    logic [2:0]  phase = '0;
    logic [7:0]  tx_byte = '0;
    logic [3:0]  g0_io_i = '0;
    logic [3:0]  g1_io_i = '0;
    logic [7:0]  rx_byte;
    logic [3:0]  g0_io_o, g1_io_o;
    logic        g0_io_oe, g1_io_oe, cs0_n, cs1_n, addr_err;
    logic [23:0] dev_addr;
    logic [0:0]  dev_bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qspi_lane_router u_qspi_lane_router (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_stack_sel(cfg_stack_sel),
        .txn_start(txn_start), .txn_end(txn_end), .txn_use_addr(txn_use_addr),
        .host_addr(host_addr), .host_len(host_len), .phase(phase), .tx_byte(tx_byte),
        .rx_byte(rx_byte), .g0_io_i(g0_io_i), .g0_io_o(g0_io_o), .g0_io_oe(g0_io_oe),
        .g1_io_i(g1_io_i), .g1_io_o(g1_io_o), .g1_io_oe(g1_io_oe),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .dev_addr(dev_addr), .dev_bank(dev_bank),
        .addr_err(addr_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic open_txn(input logic [1:0] m, input logic s, input logic u,
                            input logic [31:0] a, input logic [15:0] l);
        @(negedge clk);
        cfg_mode = m; cfg_stack_sel = s; txn_use_addr = u; host_addr = a; host_len = l;
        txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic close_txn();
        @(negedge clk);
        phase = 3'd0;
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
    endtask

    task automatic drive(input logic [2:0] p, input logic [7:0] t,
                         input logic [3:0] i0, input logic [3:0] i1);
        phase = p; tx_byte = t; g0_io_i = i0; g1_io_i = i1;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs", {cs1_n, cs0_n}, 2'b11);
        chk("R1 err", addr_err, 1'b0);
        chk("R1 oe", {g1_io_oe, g0_io_oe}, 2'b00);
        rst = 1'b0;

        // Vector table: selects, errors, address translation and banking
        for (int i = 0; i < NV; i++) begin
            open_txn(VEC[i].mode, VEC[i].sel, VEC[i].use_a, VEC[i].addr, VEC[i].len);
            // R6 R7 R8 R9 R10: chip selects and error flag
            chk($sformatf("R8/R9/R10 vec%0d cs", i), {cs1_n, cs0_n}, {VEC[i].c1, VEC[i].c0});
            chk($sformatf("R7/R10 vec%0d err", i), addr_err, VEC[i].err);
            if (!VEC[i].err) begin
                // R12: 24-bit address plus bank
                chk($sformatf("R12 vec%0d addr", i), dev_addr, VEC[i].loc[23:0]);
                chk($sformatf("R12 vec%0d bank", i), dev_bank, VEC[i].loc[24]);
            end
            close_txn();
            chk($sformatf("R11 vec%0d idle cs", i), {cs1_n, cs0_n}, 2'b11);
        end

        // R2: single-mode lanes
        open_txn(2'd0, 1'b0, 1'b1, 32'h100, 16'd4);
        drive(3'd1, 8'hA5, 4'h0, 4'h0);
        chk("R2 g0 data", g0_io_o, 4'h5);
        chk("R2 oe", {g1_io_oe, g0_io_oe}, 2'b01);
        drive(3'd4, 8'h00, 4'hC, 4'h3);
        chk("R2 rx", rx_byte, 8'h0C);
        chk("R11 rdata oe", {g1_io_oe, g0_io_oe}, 2'b00);
        close_txn();

        // R3 R4 R5: parallel lanes
        open_txn(2'd1, 1'b0, 1'b1, 32'h200, 16'd8);
        drive(3'd1, 8'h3B, 4'h0, 4'h0);
        chk("R3 cmd both", {g1_io_o, g0_io_o}, 8'hBB);
        chk("R3 cmd oe", {g1_io_oe, g0_io_oe}, 2'b11);
        drive(3'd2, 8'h52, 4'h0, 4'h0);
        chk("R3 addr both", {g1_io_o, g0_io_o}, 8'h22);
        drive(3'd3, 8'h7E, 4'h0, 4'h0);
        chk("R4 split", {g1_io_o, g0_io_o}, 8'h7E);
        drive(3'd4, 8'h00, 4'h4, 4'h9);
        chk("R5 merge", rx_byte, 8'h94);
        chk("R11 par rdata oe", {g1_io_oe, g0_io_oe}, 2'b00);
        // R13: live config changes mid-transaction are ignored
        @(negedge clk);
        cfg_mode = 2'd0; host_addr = 32'h0400_0001;
        @(negedge clk);
        drive(3'd3, 8'h7E, 4'h0, 4'h0);
        chk("R13 split kept", {g1_io_oe, g1_io_o, g0_io_o}, 9'h17E);
        chk("R13 cs kept", {cs1_n, cs0_n}, 2'b00);
        chk("R13 addr kept", dev_addr, 24'h000100);
        close_txn();

        // R8: stacked upper device uses group 0 only
        open_txn(2'd2, 1'b0, 1'b1, 32'h0200_0040, 16'd1);
        drive(3'd3, 8'h6D, 4'h0, 4'h0);
        chk("R8 g0", g0_io_o, 4'hD);
        chk("R8 oe", {g1_io_oe, g0_io_oe}, 2'b01);
        drive(3'd4, 8'h00, 4'hA, 4'h5);
        chk("R8 rx", rx_byte, 8'h0A);
        close_txn();

        // R10: rejected transaction drives nothing
        open_txn(2'd1, 1'b0, 1'b1, 32'h0000_0003, 16'd2);
        drive(3'd3, 8'hFF, 4'h0, 4'h0);
        chk("R10 err oe", {g1_io_oe, g0_io_oe}, 2'b00);
        close_txn();

        // R11: idle phase with command phase presented but no transaction
        drive(3'd1, 8'h11, 4'h0, 4'h0);
        chk("R11 idle oe", {g1_io_oe, g0_io_oe}, 2'b00);
        phase = 3'd0;

        // R1: reset mid-transaction returns to the quiet state
        open_txn(2'd1, 1'b0, 1'b1, 32'h10, 16'd2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset mid", {cs1_n, cs0_n}, 2'b11);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule